// File: doc/BRIEF.md
# Command-Byte Three-Wire Serial Port

This block is a slave port for a three-wire serial link. The three lines are a transaction enable, a serial clock and one bidirectional data line. The port runs on a fast system clock and oversamples all three lines. Each transaction opens when the enable line rises, and its first eight serial clocks carry a command byte. That byte selects one of two 32-bit counters for a read or a write, or it loads a three-bit oscillator trim code. It can also mark either counter, or both, for clearing. The counters are not part of this block. The port talks to the counter core only through one-cycle strobes: snapshot, jam-load, clear and trim.

On a read, the port captures the selected counter at the end of the command byte. It then shifts the captured word out least-significant bit first, one bit per serial-clock falling edge. It drives the data line only while the serial clock is low. On a write, it collects 32 bits on the rising edges and issues a single jam-load strobe carrying the whole word. Clear requests wait until the enable line falls. While main power is reported invalid, the port stays idle and ignores every line.

Top module: `ser3w_cmd_port`

## Requirements
- R1: After reset, and whenever the enable line is low, the data output enable is 0 and no strobe fires.
- R2: The command byte is sampled on the first 8 serial-clock rising edges, least-significant bit first. Bit 7 selects the continuous counter and bit 6 selects the power-gated counter. Bits 5..3 hold the trim code. Bit 2 requests a clear of the continuous counter and bit 1 a clear of the power-gated counter. Bit 0 chooses read when it is 1 and write when it is 0. At most one of the snapshot, jam and trim strobes fires in any cycle.
- R3: When bits 7 and 6 are both 1, a trim strobe carries bits 5..3 after the 8th rising edge. All later serial clocks in that transaction are ignored. The strobe comes 3 system cycles after the raw edge.
- R4: A read command with exactly one select bit fires a snapshot strobe (select 0 = continuous, 1 = power-gated) at the end of the command byte. The selected counter value then appears LSB first on 32 falling edges, starting with the falling edge right after the 8th rising edge.
- R5: The data line is driven only during a read, while the serial clock is low. It is released while the clock is high.
- R6: A write command with exactly one select bit takes 32 data bits, LSB first, on the next 32 rising edges. On the 32nd it fires one jam strobe with that word and the select. Later clocks are ignored until the enable line is cycled.
- R7: Clear strobes fire when the enable line falls, one per requested counter, and only if the full command byte was received. This also holds for a command with neither select bit set, which has no data phase.
- R8: Lowering the enable line mid-transfer aborts it at once. A partial write gives no jam, a partial command gives no clear, and the data line is released.
- R9: While power-valid is low, the port ignores every line and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Main power valid (system-clock domain) |
| sel_i | input | 1 | Transaction enable line, raw |
| sck_i | input | 1 | Serial clock, raw |
| sd_i | input | 1 | Data line input, raw |
| sd_o | output | 1 | Data line output value |
| sd_oe_o | output | 1 | Data line output enable |
| cnt_cont_i | input | DATA_W | Continuous counter value |
| cnt_pwr_i | input | DATA_W | Power-gated counter value |
| snap_stb_o | output | 1 | Snapshot strobe |
| snap_sel_o | output | 1 | Snapshot target (0 continuous, 1 power-gated) |
| jam_stb_o | output | 1 | Jam-load strobe |
| jam_sel_o | output | 1 | Jam-load target |
| jam_data_o | output | DATA_W | Word to jam-load |
| clr_cont_o | output | 1 | Clear strobe, continuous counter |
| clr_pwr_o | output | 1 | Clear strobe, power-gated counter |
| trim_stb_o | output | 1 | Trim load strobe |
| trim_code_o | output | 3 | Trim code |

## Verification
Every strobe is due 3 system cycles after the raw serial edge that causes it: two synchronizer flops, then the output register. A read bit is valid 3 cycles after the raw falling edge. The bench holds each serial half-period for 10 system cycles, so it samples the data line and output enable 8 to 10 cycles after each edge, when they have settled. One trim transaction counts the exact 3-cycle latency. All other strobes go to a scoreboard queue, and each transaction must have drained that queue within 12 cycles of the enable line falling.

// File: rtl/ser3w_pkg.sv
package ser3w_pkg;
  localparam int CMD_W      = 8;
  localparam int TRIM_W     = 3;
  localparam int B_SEL_CONT = 7;
  localparam int B_SEL_PWR  = 6;
  localparam int B_TRIM_LO  = 3;
  localparam int B_CLR_CONT = 2;
  localparam int B_CLR_PWR  = 1;
  localparam int B_READ     = 0;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_RD, ST_WR, ST_DONE} port_st_e;
  typedef enum logic [1:0] {OP_NONE, OP_TRIM, OP_READ, OP_WRITE} cmd_op_e;

  function automatic cmd_op_e cmd_op(input logic [CMD_W-1:0] c);
    if (c[B_SEL_CONT] && c[B_SEL_PWR]) return OP_TRIM;
    if (c[B_SEL_CONT] || c[B_SEL_PWR]) return c[B_READ] ? OP_READ : OP_WRITE;
    return OP_NONE;
  endfunction

  function automatic logic [TRIM_W-1:0] cmd_trim(input logic [CMD_W-1:0] c);
    return c[B_TRIM_LO +: TRIM_W];
  endfunction
endpackage

// File: rtl/ser3w_sync.sv
module ser3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], raw_i[l]};
    end
    assign lvl_o[l] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ser3w_shreg.sv
module ser3w_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  function automatic logic [W-1:0] lsb_in(input logic [W-1:0] v, input logic b);
    return {b, v[W-1:1]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= lsb_in(q_o, bit_i);
  end
endmodule

// File: rtl/ser3w_cmd_port.sv
module ser3w_cmd_port import ser3w_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwr_ok_i,
  input  logic              sel_i,
  input  logic              sck_i,
  input  logic              sd_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  input  logic [DATA_W-1:0] cnt_cont_i,
  input  logic [DATA_W-1:0] cnt_pwr_i,
  output logic              snap_stb_o,
  output logic              snap_sel_o,
  output logic              jam_stb_o,
  output logic              jam_sel_o,
  output logic [DATA_W-1:0] jam_data_o,
  output logic              clr_cont_o,
  output logic              clr_pwr_o,
  output logic              trim_stb_o,
  output logic [TRIM_W-1:0] trim_code_o
);
  localparam int CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] CMD_LAST  = CW'(CMD_W - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] DATA_END  = CW'(DATA_W);

  // synchronized lines: [2]=sel, [1]=sck, [0]=sd
  logic [2:0] lvl;
  ser3w_sync #(.LINES(3), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i({sel_i, sck_i, sd_i}), .lvl_o(lvl));

  logic sel_lvl, sck_lvl, sd_lvl, sck_dly_q;
  assign sel_lvl = lvl[2];
  assign sck_lvl = lvl[1];
  assign sd_lvl  = lvl[0];

  port_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic cmd_ok_q, tgt_q, dq_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;

  // named events
  logic active, sck_rise_ev, sck_fall_ev, cmd_last_ev, rd_shift_ev, wr_shift_ev, wr_last_ev;
  logic snap_ev, abort_ev;
  logic [CMD_W-1:0] cmd_next;
  cmd_op_e op_next;

  assign active      = pwr_ok_i && sel_lvl;
  assign sck_rise_ev = active && sck_lvl && !sck_dly_q;
  assign sck_fall_ev = active && !sck_lvl && sck_dly_q;
  assign cmd_next    = {sd_lvl, cmd_q[CMD_W-1:1]};
  assign op_next     = cmd_op(cmd_next);
  assign cmd_last_ev = (st_q == ST_CMD) && sck_rise_ev && (cnt_q == CMD_LAST);
  assign snap_ev     = cmd_last_ev && (op_next == OP_READ);
  assign rd_shift_ev = (st_q == ST_RD) && sck_fall_ev && (cnt_q < DATA_END);
  assign wr_shift_ev = (st_q == ST_WR) && sck_rise_ev;
  assign wr_last_ev  = wr_shift_ev && (cnt_q == DATA_LAST);
  assign abort_ev    = pwr_ok_i && !sel_lvl && (st_q != ST_IDLE);

  ser3w_shreg #(.W(CMD_W)) cmd_sh_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i((st_q == ST_IDLE) && active), .load_val_i('0),
    .shift_i((st_q == ST_CMD) && sck_rise_ev), .bit_i(sd_lvl), .q_o(cmd_q));

  ser3w_shreg #(.W(DATA_W)) data_sh_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .load_i(snap_ev), .load_val_i(cmd_next[B_SEL_PWR] ? cnt_pwr_i : cnt_cont_i),
    .shift_i(rd_shift_ev || wr_shift_ev), .bit_i(sd_lvl), .q_o(data_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_dly_q <= 1'b0;
    else         sck_dly_q <= sck_lvl;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; cnt_q <= '0; cmd_ok_q <= 1'b0; tgt_q <= 1'b0; dq_q <= 1'b0;
      snap_stb_o <= 1'b0; snap_sel_o <= 1'b0; jam_stb_o <= 1'b0; jam_sel_o <= 1'b0;
      jam_data_o <= '0; clr_cont_o <= 1'b0; clr_pwr_o <= 1'b0;
      trim_stb_o <= 1'b0; trim_code_o <= '0;
    end else if (!pwr_ok_i) begin
      st_q <= ST_IDLE; cnt_q <= '0; cmd_ok_q <= 1'b0;
      snap_stb_o <= 1'b0; jam_stb_o <= 1'b0; clr_cont_o <= 1'b0; clr_pwr_o <= 1'b0;
      trim_stb_o <= 1'b0;
    end else begin
      snap_stb_o <= 1'b0; jam_stb_o <= 1'b0; clr_cont_o <= 1'b0; clr_pwr_o <= 1'b0;
      trim_stb_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (sel_lvl) begin st_q <= ST_CMD; cnt_q <= '0; cmd_ok_q <= 1'b0; end
        ST_CMD: if (sck_rise_ev) begin
          cnt_q <= cnt_q + 1'b1;
          if (cmd_last_ev) begin
            cnt_q    <= '0;
            cmd_ok_q <= 1'b1;
            tgt_q    <= cmd_next[B_SEL_PWR];
            unique case (op_next)
              OP_TRIM:  begin trim_stb_o <= 1'b1; trim_code_o <= cmd_trim(cmd_next); st_q <= ST_DONE; end
              OP_READ:  begin snap_stb_o <= 1'b1; snap_sel_o <= cmd_next[B_SEL_PWR]; st_q <= ST_RD; end
              OP_WRITE: st_q <= ST_WR;
              default:  st_q <= ST_DONE;
            endcase
          end
        end
        ST_RD: begin
          if (rd_shift_ev) begin dq_q <= data_q[0]; cnt_q <= cnt_q + 1'b1; end
          else if (sck_rise_ev && (cnt_q == DATA_END)) st_q <= ST_DONE;
        end
        ST_WR: if (wr_shift_ev) begin
          cnt_q <= cnt_q + 1'b1;
          if (wr_last_ev) begin
            jam_stb_o  <= 1'b1;
            jam_sel_o  <= tgt_q;
            jam_data_o <= {sd_lvl, data_q[DATA_W-1:1]};
            st_q       <= ST_DONE;
          end
        end
        default: ;
      endcase
      if (abort_ev) begin
        st_q       <= ST_IDLE;
        clr_cont_o <= cmd_ok_q && cmd_q[B_CLR_CONT];
        clr_pwr_o  <= cmd_ok_q && cmd_q[B_CLR_PWR];
      end
    end
  end

  assign sd_o    = dq_q;
  assign sd_oe_o = active && (st_q == ST_RD) && (cnt_q != '0) && !sck_lvl && !sck_dly_q;

  // R2
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({snap_stb_o, jam_stb_o, trim_stb_o}));
  // R3
  trim_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trim_stb_o |-> (st_q == ST_DONE));
  // R5
  oe_read_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> (cmd_ok_q && cmd_q[B_READ]));
  // R6
  jam_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_stb_o |=> !jam_stb_o);
  // R7
  clr_after_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cont_o || clr_pwr_o) |-> ((st_q == ST_IDLE) && $past(cmd_ok_q)));
  // R9
  pwr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !(snap_stb_o || jam_stb_o || trim_stb_o || clr_cont_o || clr_pwr_o));
endmodule

// File: tb/ser3w_cmd_port_tb_top.sv
`timescale 1ns/1ps
module ser3w_cmd_port_tb_top;
  localparam int K_SNAP = 0, K_JAM = 1, K_CLR = 2, K_TRIM = 3;
  localparam logic [31:0] V_CONT = 32'hA5C3_0F1E;
  localparam logic [31:0] V_PWR  = 32'h1234_8001;

  typedef struct { int kind; logic sel; logic [31:0] data; string req; } exp_t;
  exp_t exp_q[$];

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, sel = 1'b0, sck = 1'b0, sd = 1'b0;
  logic sd_o, sd_oe, snap_stb, snap_sel, jam_stb, jam_sel, clr_c, clr_p, trim_stb;
  logic [31:0] jam_data;
  logic [2:0] trim_code;
  int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0, oe_cnt = 0;

  always #5 clk = ~clk;

  ser3w_cmd_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .sel_i(sel), .sck_i(sck), .sd_i(sd),
    .sd_o(sd_o), .sd_oe_o(sd_oe), .cnt_cont_i(V_CONT), .cnt_pwr_i(V_PWR),
    .snap_stb_o(snap_stb), .snap_sel_o(snap_sel), .jam_stb_o(jam_stb), .jam_sel_o(jam_sel),
    .jam_data_o(jam_data), .clr_cont_o(clr_c), .clr_pwr_o(clr_p),
    .trim_stb_o(trim_stb), .trim_code_o(trim_code));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic mon_cmp(input int kind, input logic s, input logic [31:0] d);
    exp_t e;
    m_chk++;
    if (exp_q.size() == 0) begin
      m_err++;
      $display("FAIL unexpected strobe (R1/R8/R9 scope): actual kind %0d data %h expected none", kind, d);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.sel !== s || e.data !== d) begin
        m_err++;
        $display("FAIL %s strobe: actual kind %0d sel %b data %h expected kind %0d sel %b data %h",
                 e.req, kind, s, d, e.kind, e.sel, e.data);
      end
    end
  endtask

  // monitor: scoreboard pop/compare, sampled on the falling system-clock edge
  always @(negedge clk) if (rst_n) begin
    if (sd_oe) oe_cnt++;
    if (snap_stb) mon_cmp(K_SNAP, snap_sel, 32'h0);
    if (jam_stb) mon_cmp(K_JAM, jam_sel, jam_data);
    if (clr_c || clr_p) mon_cmp(K_CLR, 1'b0, {30'h0, clr_p, clr_c});
    if (trim_stb) mon_cmp(K_TRIM, 1'b0, {29'h0, trim_code});
  end

  task automatic push(input int kind, input logic s, input logic [31:0] d, input string req);
    exp_t e;
    e.kind = kind; e.sel = s; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b);
    sd = b; cyc(4); sck = 1'b1; cyc(10); sck = 1'b0; cyc(10);
  endtask

  task automatic start();
    @(negedge clk); sel = 1'b1; cyc(10);
  endtask

  task automatic stop();
    sck = 1'b1; cyc(5); sel = 1'b0; cyc(5); sck = 1'b0; cyc(12);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) bit_clk(v[i]);
  endtask

  task automatic drained(input string req);
    chk(exp_q.size() == 0, req, "expected strobes delivered", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic read_word(input logic [31:0] exp, input string req);
    logic [31:0] w = '0;
    int oe_lo = 0, oe_hi_bad = 0;
    if (sd_oe) oe_lo++;
    w[0] = sd_o;
    for (int i = 1; i < 32; i++) begin
      sck = 1'b1; cyc(10);
      if (sd_oe) oe_hi_bad++;
      sck = 1'b0; cyc(10);
      if (sd_oe) oe_lo++;
      w[i] = sd_o;
    end
    sck = 1'b1; cyc(10);
    if (sd_oe) oe_hi_bad++;
    chk(w === exp, req, "read word", w, exp);
    chk(oe_lo == 32, "R5", "driven during clock low", oe_lo, 32);
    chk(oe_hi_bad == 0, "R5", "released during clock high", oe_hi_bad, 0);
  endtask

  initial begin
    int lat, oe0;
    cyc(3); rst_n = 1'b1; cyc(5);
    // R1 reset state
    chk(sd_oe == 1'b0, "R1", "oe after reset", sd_oe, 0);
    chk({snap_stb, jam_stb, clr_c, clr_p, trim_stb} == 5'b0, "R1", "strobes after reset",
        {snap_stb, jam_stb, clr_c, clr_p, trim_stb}, 0);

    // R3 trim: cmd 0xE8 -> trim code 5, exact 3-cycle latency, later clocks ignored
    oe0 = oe_cnt;
    push(K_TRIM, 1'b0, 32'd5, "R3");
    start(); send_bits(32'hE8, 7);
    sd = 1'b1; cyc(4); sck = 1'b1; lat = 0;
    for (int k = 1; k <= 6; k++) begin @(negedge clk); if (trim_stb && lat == 0) lat = k; end
    cyc(4); sck = 1'b0; cyc(10);
    chk(lat == 3, "R3", "trim strobe latency", lat, 3);
    send_bits(32'hFFFF_FFFF, 10);
    stop(); drained("R3");
    chk(oe_cnt == oe0, "R3", "no drive after trim", oe_cnt - oe0, 0);

    // R4 read continuous counter, R2 field decoding
    push(K_SNAP, 1'b0, 32'h0, "R4");
    start(); send_bits(32'h81, 8); read_word(V_CONT, "R4"); stop(); drained("R4");

    // R4 read power-gated counter
    push(K_SNAP, 1'b1, 32'h0, "R4");
    start(); send_bits(32'h41, 8); read_word(V_PWR, "R4"); stop(); drained("R4");

    // R6 write continuous counter, extra clocks ignored
    oe0 = oe_cnt;
    push(K_JAM, 1'b0, 32'hDEAD_BEEF, "R6");
    start(); send_bits(32'h80, 8); send_bits(32'hDEAD_BEEF, 32); send_bits(32'h0, 6);
    stop(); drained("R6");
    chk(oe_cnt == oe0, "R5", "no drive in write", oe_cnt - oe0, 0);

    // R7 write power-gated with both clears requested (0x46)
    push(K_JAM, 1'b1, 32'h0F0F_1234, "R6");
    push(K_CLR, 1'b0, 32'h3, "R7");
    start(); send_bits(32'h46, 8); send_bits(32'h0F0F_1234, 32); stop(); drained("R7");

    // R7 no-data command, clear continuous only (0x04)
    oe0 = oe_cnt;
    push(K_CLR, 1'b0, 32'h1, "R7");
    start(); send_bits(32'h04, 8); send_bits(32'h0, 3); stop(); drained("R7");
    chk(oe_cnt == oe0, "R7", "no drive for no-data command", oe_cnt - oe0, 0);

    // R2 no-data command, clear power-gated only (0x02)
    push(K_CLR, 1'b0, 32'h2, "R2");
    start(); send_bits(32'h02, 8); stop(); drained("R2");

    // R8 abort a write after 10 data bits: no jam
    start(); send_bits(32'h80, 8); send_bits(32'h3FF, 10); stop(); drained("R8");

    // R8 abort a read after 5 bits: data line released
    push(K_SNAP, 1'b0, 32'h0, "R8");
    start(); send_bits(32'h81, 8); send_bits(32'h0, 4);
    sel = 1'b0; cyc(12);
    chk(sd_oe == 1'b0, "R8", "oe after abort", sd_oe, 0);
    drained("R8");

    // R8 partial command with clear bits already shifted in: no clear
    start(); send_bits(32'h06, 4); stop(); drained("R8");

    // R9 power invalid: trim and write ignored
    oe0 = oe_cnt;
    pwr_ok = 1'b0;
    start(); send_bits(32'hC8, 8); stop();
    start(); send_bits(32'h86, 8); send_bits(32'h1111_1111, 32); stop();
    start(); send_bits(32'h81, 8); send_bits(32'h0, 8); stop();
    drained("R9");
    chk(oe_cnt == oe0, "R9", "no drive without power", oe_cnt - oe0, 0);
    pwr_ok = 1'b1; cyc(5);

    // R1 port works again after power returns; enable low keeps port quiet
    push(K_TRIM, 1'b0, 32'd3, "R1");
    start(); send_bits(32'hD8, 8); stop(); drained("R1");
    send_bits(32'hFF, 8); cyc(10); drained("R1");

    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk + 1, n_err + m_err + 1);
    $finish;
  end
endmodule